// File: doc/BRIEF.md
# Audio Processor I/O Register Page

This block is the sixteen-byte register page that sits on the bus of a small audio processor and occupies addresses 0x00F0 to 0x00FF. It decodes processor reads and writes that fall in the page. It holds a locked configuration byte and a control byte. It provides a window onto the sound generator's register file, four inbound mailbox bytes written by the main CPU, and four outbound mailbox bytes read by the main CPU. It also holds two spare bytes, three timer target bytes and three 4-bit timer output counters.

Some accesses have side effects. Reading a timer output counter returns its value and clears it in the same access. A write to the configuration byte is dropped while the processor's P flag is high. A write to the control byte can zero pairs of inbound mailbox bytes at once. The same write pulses a per-timer clear when a timer's enable goes from 0 to 1. Every processor write is also forwarded unchanged to RAM, including writes that land in the page. Reads outside the page return the RAM data input.

The timer prescalers are outside this block. They deliver one tick per timer, and each tick advances that timer's output counter.

Top module: `apu_io_page`

## Requirements
- R1: After reset the boot ROM enable is 1. The timer enables, the configuration fields, the outbound mailbox bytes, the sound register address and all counters are 0.
- R2: The page is selected only when bus_addr[15:4] is 0x00F. Reads outside it return ram_rdata. Writes outside it change no page register.
- R3: A write to 0xF0 while p_flag is 1 is ignored. Otherwise the written byte sets the configuration outputs: clock speed [7:6], timer speed [5:4], timer run bit 3, RAM off bit 2, RAM write-ok bit 1 and timer halt bit 0.
- R4: A write to 0xF1 loads boot_rom_en from bit 7. Bit 5 zeroes inbound bytes 2 and 3, and bit 4 zeroes inbound bytes 0 and 1. Such a clear beats a host write to the same byte in the same cycle.
- R5: Bits [2:0] of a write to 0xF1 load tmr_en[2:0]. In that write cycle tmr_clr[i] is 1 exactly for those timers whose enable goes from 0 to 1, and the output counter of that timer becomes 0.
- R6: 0xF2 holds the 8-bit sound register address and reads back in full, and dsp_addr carries its low 7 bits. A write to 0xF3 raises dsp_we with dsp_wdata equal to the bus data only when address bit 7 is 0. A read of 0xF3 returns dsp_rdata.
- R7: Each tick on tmr_tick[i] advances counter i by 1, wrapping from 15 to 0. A read of 0xFD, 0xFE or 0xFF returns counter 0, 1 or 2 in bits [3:0] with zeros above, and clears that counter. The clear wins over a tick in the same cycle.
- R8: Reads of 0xF0, 0xF1, 0xFA, 0xFB and 0xFC return 0x00. Writes to 0xFD to 0xFF change nothing.
- R9: A read of 0xF4 to 0xF7 returns the inbound byte selected by bus_addr[1:0]. A write there sets the outbound byte of that index, and outbound byte k is out_mbox[8k+7:8k]. A host write loads inbound byte host_idx.
- R10: 0xF8 and 0xF9 are spare bytes that read back what was written. Writes to 0xFA to 0xFC set timer targets 0 to 2, and target k is tmr_target[8k+7:8k].
- R11: Every bus write drives ram_we, ram_addr and ram_wdata with the bus values in the same cycle, both inside and outside the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor address |
| bus_wr | input | 1 | Processor write strobe |
| bus_rd | input | 1 | Processor read strobe |
| bus_wdata | input | 8 | Processor write data |
| bus_rdata | output | 8 | Processor read data (combinational) |
| p_flag | input | 1 | Processor P flag; locks the configuration byte |
| ram_rdata | input | 8 | RAM read data for addresses outside the page |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| dsp_addr | output | 7 | Sound register address |
| dsp_we | output | 1 | Sound register write strobe |
| dsp_wdata | output | 8 | Sound register write data |
| dsp_rdata | input | 8 | Sound register read data |
| host_wr | input | 1 | Main CPU write to an inbound mailbox byte |
| host_idx | input | 2 | Inbound byte index |
| host_wdata | input | 8 | Inbound byte data |
| out_mbox | output | 32 | Outbound mailbox bytes, byte k at [8k+7:8k] |
| cfg_clk_speed | output | 2 | Configured clock speed |
| cfg_tmr_speed | output | 2 | Configured timer speed |
| cfg_tmr_run | output | 1 | Configured timer run bit |
| cfg_ram_off | output | 1 | Configured RAM off bit |
| cfg_ram_wr_ok | output | 1 | Configured RAM write-ok bit |
| cfg_tmr_halt | output | 1 | Configured timer halt bit |
| boot_rom_en | output | 1 | Boot ROM enable |
| tmr_en | output | 3 | Timer enables |
| tmr_clr | output | 3 | Timer stage clear pulses on an enable rising edge |
| tmr_tick | input | 3 | Prescaler ticks, one per timer |
| tmr_target | output | 24 | Timer targets, target k at [8k+7:8k] |

## Verification
The bench checks that a read of a counter both returns the value and clears it. A design that cleared before returning would read 0, and one that never cleared would read a growing count on the second read. The bench also checks counter wrap past 15, and that a clear wins over a tick in the same cycle.

The bench writes the configuration byte with the P flag high. It sets high sound-address bit 7 before a data write, so a leaky gate would show as a stray write strobe. It rewrites the control byte with timers already enabled, so a level-based clear instead of an edge-based one would show as a second clear pulse. It also issues a mailbox clear and a host write to the same byte in one cycle. Random mailbox, spare and target traffic is checked against a model in the bench, and so are addresses that share low bits with the page but lie outside it.

// File: rtl/apu_io_pkg.sv
package apu_io_pkg;

    localparam int DW = 8;
    localparam int AW = 16;
    localparam logic [AW-5:0] PAGE_HI = 12'h00F;

    typedef enum logic [3:0] {
        SEL_CFG  = 4'h0,
        SEL_CTRL = 4'h1,
        SEL_DSPA = 4'h2,
        SEL_DSPD = 4'h3,
        SEL_MB0  = 4'h4,
        SEL_MB1  = 4'h5,
        SEL_MB2  = 4'h6,
        SEL_MB3  = 4'h7,
        SEL_AUX0 = 4'h8,
        SEL_AUX1 = 4'h9,
        SEL_TGT0 = 4'hA,
        SEL_TGT1 = 4'hB,
        SEL_TGT2 = 4'hC,
        SEL_CNT0 = 4'hD,
        SEL_CNT1 = 4'hE,
        SEL_CNT2 = 4'hF
    } reg_sel_e;

    // bit order matches the configuration byte layout
    typedef struct packed {
        logic [1:0] clk_speed;
        logic [1:0] tmr_speed;
        logic       tmr_run;
        logic       ram_off;
        logic       ram_wr_ok;
        logic       tmr_halt;
    } cfg_t;

    // control byte bit positions
    localparam int CTRL_BOOT    = 7;
    localparam int CTRL_CLR_HI  = 5;
    localparam int CTRL_CLR_LO  = 4;

    function automatic logic in_page(input logic [AW-1:0] a);
        return a[AW-1:4] == PAGE_HI;
    endfunction

endpackage

// File: rtl/apu_io_inbox.sv
module apu_io_inbox #(
    parameter int N_PORT = 4,
    parameter int DW     = 8,
    localparam int IW    = $clog2(N_PORT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        host_wr,
    input  logic [IW-1:0]               host_idx,
    input  logic [DW-1:0]               host_wdata,
    input  logic [N_PORT-1:0]           clr_mask,
    output logic [N_PORT-1:0][DW-1:0]   q
);
    for (genvar i = 0; i < N_PORT; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (clr_mask[i]) begin
                q[i] <= '0;
            end else if (host_wr && host_idx == IW'(i)) begin
                q[i] <= host_wdata;
            end
        end
    end
endmodule

// File: rtl/apu_io_tcount.sv
module apu_io_tcount #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clr,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/apu_io_page.sv
module apu_io_page
    import apu_io_pkg::*;
#(
    parameter int N_TMR  = 3,
    parameter int N_MBOX = 4,
    parameter int N_AUX  = 2,
    parameter int CNT_W  = 4,
    localparam int MIW   = $clog2(N_MBOX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic                p_flag,
    input  logic [DW-1:0]       ram_rdata,
    output logic                ram_we,
    output logic [AW-1:0]       ram_addr,
    output logic [DW-1:0]       ram_wdata,
    output logic [6:0]          dsp_addr,
    output logic                dsp_we,
    output logic [DW-1:0]       dsp_wdata,
    input  logic [DW-1:0]       dsp_rdata,
    input  logic                host_wr,
    input  logic [MIW-1:0]      host_idx,
    input  logic [DW-1:0]       host_wdata,
    output logic [N_MBOX*DW-1:0] out_mbox,
    output logic [1:0]          cfg_clk_speed,
    output logic [1:0]          cfg_tmr_speed,
    output logic                cfg_tmr_run,
    output logic                cfg_ram_off,
    output logic                cfg_ram_wr_ok,
    output logic                cfg_tmr_halt,
    output logic                boot_rom_en,
    output logic [N_TMR-1:0]    tmr_en,
    output logic [N_TMR-1:0]    tmr_clr,
    input  logic [N_TMR-1:0]    tmr_tick,
    output logic [N_TMR*DW-1:0] tmr_target
);
    localparam int AXW = (N_AUX > 1) ? $clog2(N_AUX) : 1;

    logic                         hit;
    reg_sel_e                     sel;
    logic                         wr_hit;
    logic                         rd_hit;
    logic [1:0]                   tsel;

    cfg_t                         cfg_q;
    logic                         boot_q;
    logic [N_TMR-1:0]             en_q;
    logic [DW-1:0]                dspa_q;
    logic [N_MBOX-1:0][DW-1:0]    outb_q;
    logic [N_AUX-1:0][DW-1:0]     aux_q;
    logic [N_TMR-1:0][DW-1:0]     tgt_q;
    logic [N_MBOX-1:0][DW-1:0]    inb_q;
    logic [N_MBOX-1:0]            inb_clr;
    logic [N_TMR-1:0][CNT_W-1:0]  cnt_q;
    logic [N_TMR-1:0]             cnt_clr;

    assign hit    = in_page(bus_addr);
    assign sel    = reg_sel_e'(bus_addr[3:0]);
    assign wr_hit = bus_wr && hit;
    assign rd_hit = bus_rd && hit;

    // every write also reaches RAM
    assign ram_we    = bus_wr;
    assign ram_addr  = bus_addr;
    assign ram_wdata = bus_wdata;

    // sound register window
    assign dsp_addr  = dspa_q[6:0];
    assign dsp_wdata = bus_wdata;
    assign dsp_we    = wr_hit && sel == SEL_DSPD && !dspa_q[7];

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            boot_q <= 1'b1;
            en_q   <= '0;
            dspa_q <= '0;
            outb_q <= '0;
            aux_q  <= '0;
            tgt_q  <= '0;
        end else if (wr_hit) begin
            case (sel)
                SEL_CFG:  if (!p_flag) cfg_q <= cfg_t'(bus_wdata);
                SEL_CTRL: begin
                    boot_q <= bus_wdata[CTRL_BOOT];
                    en_q   <= bus_wdata[N_TMR-1:0];
                end
                SEL_DSPA: dspa_q <= bus_wdata;
                SEL_MB0, SEL_MB1, SEL_MB2, SEL_MB3:
                    outb_q[bus_addr[MIW-1:0]] <= bus_wdata;
                SEL_AUX0, SEL_AUX1:
                    aux_q[bus_addr[AXW-1:0]] <= bus_wdata;
                SEL_TGT0, SEL_TGT1, SEL_TGT2:
                    tgt_q[2'(bus_addr[3:0] - 4'hA)] <= bus_wdata;
                default: ;
            endcase
        end
    end

    // control-byte side effects
    for (genvar i = 0; i < N_MBOX; i++) begin : g_inb_clr
        localparam int CB = CTRL_CLR_LO + (i / 2);
        assign inb_clr[i] = wr_hit && sel == SEL_CTRL && bus_wdata[CB];
    end

    assign tsel = 2'(bus_addr[3:0] - 4'hD);

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        assign tmr_clr[i] = wr_hit && sel == SEL_CTRL && bus_wdata[i] && !en_q[i];
        assign cnt_clr[i] = tmr_clr[i] ||
                            (rd_hit && bus_addr[3:0] >= 4'hD && tsel == 2'(i));
        apu_io_tcount #(.CW(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .tick  (tmr_tick[i]),
            .clr   (cnt_clr[i]),
            .count (cnt_q[i])
        );
    end

    apu_io_inbox #(.N_PORT(N_MBOX), .DW(DW)) u_inbox (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .clr_mask   (inb_clr),
        .q          (inb_q)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (!hit) begin
            bus_rdata = ram_rdata;
        end else begin
            case (sel)
                SEL_DSPA: bus_rdata = dspa_q;
                SEL_DSPD: bus_rdata = dsp_rdata;
                SEL_MB0, SEL_MB1, SEL_MB2, SEL_MB3:
                    bus_rdata = inb_q[bus_addr[MIW-1:0]];
                SEL_AUX0, SEL_AUX1:
                    bus_rdata = aux_q[bus_addr[AXW-1:0]];
                SEL_CNT0, SEL_CNT1, SEL_CNT2:
                    bus_rdata = DW'(cnt_q[tsel]);
                default: bus_rdata = '0;
            endcase
        end
    end

    assign out_mbox      = outb_q;
    assign tmr_target    = tgt_q;
    assign cfg_clk_speed = cfg_q.clk_speed;
    assign cfg_tmr_speed = cfg_q.tmr_speed;
    assign cfg_tmr_run   = cfg_q.tmr_run;
    assign cfg_ram_off   = cfg_q.ram_off;
    assign cfg_ram_wr_ok = cfg_q.ram_wr_ok;
    assign cfg_tmr_halt  = cfg_q.tmr_halt;
    assign boot_rom_en   = boot_q;
    assign tmr_en        = en_q;

endmodule

// File: rtl/apu_io_page_chk.sv
module apu_io_page_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        p_flag,
    input logic        ram_we,
    input logic [15:0] ram_addr,
    input logic [7:0]  ram_wdata,
    input logic        dsp_we,
    input logic [7:0]  dspa_q,
    input logic [7:0]  cfg_bits,
    input logic [31:0] inb_bits,
    input logic [2:0]  tmr_en,
    input logic [2:0]  tmr_clr,
    input logic        boot_rom_en
);
    logic primed;
    always_ff @(posedge clk) primed <= !rst;

    a_r11_ram_forward: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (ram_we && ram_addr == bus_addr && ram_wdata == bus_wdata));

    a_r6_dsp_gate: assert property (@(posedge clk) disable iff (rst)
        dsp_we |-> !dspa_q[7]);

    a_r3_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 16'h00F0 && p_flag) |=> $stable(cfg_bits));

    a_r4_inbox_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 16'h00F1 && bus_wdata[4]) |=> inb_bits[15:0] == 16'h0);

    a_r5_clr_on_rise: assert property (@(posedge clk) disable iff (rst)
        primed |-> ((tmr_en & ~$past(tmr_en)) == $past(tmr_clr)));

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (boot_rom_en && tmr_en == 3'b000 && cfg_bits == 8'h00));
endmodule

bind apu_io_page apu_io_page_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .p_flag      (p_flag),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .dsp_we      (dsp_we),
    .dspa_q      (dspa_q),
    .cfg_bits    (cfg_q),
    .inb_bits    (inb_q),
    .tmr_en      (tmr_en),
    .tmr_clr     (tmr_clr),
    .boot_rom_en (boot_rom_en)
);

// File: tb/tb_apu_io_page.sv
module tb_apu_io_page;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        p_flag = 0;
    logic [7:0]  ram_rdata = 0;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [6:0]  dsp_addr;
    logic        dsp_we;
    logic [7:0]  dsp_wdata;
    logic [7:0]  dsp_rdata = 0;
    logic        host_wr = 0;
    logic [1:0]  host_idx = 0;
    logic [7:0]  host_wdata = 0;
    logic [31:0] out_mbox;
    logic [1:0]  cfg_clk_speed, cfg_tmr_speed;
    logic        cfg_tmr_run, cfg_ram_off, cfg_ram_wr_ok, cfg_tmr_halt;
    logic        boot_rom_en;
    logic [2:0]  tmr_en, tmr_clr;
    logic [2:0]  tmr_tick = 0;
    logic [23:0] tmr_target;

    int n_chk = 0, n_bad = 0;
    logic [2:0] w_clr;
    logic       w_dsp_we;
    logic [7:0] w_dsp_wdata;
    logic [7:0] m_inb[4], m_outb[4], m_aux[2], m_tgt[3];

    always #10 clk = ~clk;

    apu_io_page dut (.*);

    task automatic check(input logic ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        #2;
        check(ram_we && ram_addr == a && ram_wdata == d, "R11 ram forward", ram_addr, a);
        w_clr = tmr_clr; w_dsp_we = dsp_we; w_dsp_wdata = dsp_wdata;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #2;
        check(bus_rdata == e, tag, bus_rdata, e);
        @(posedge clk); #1 bus_rd = 0;
    endtask

    task automatic hwr(input logic [1:0] i, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_idx = i; host_wdata = d;
        @(posedge clk); #1 host_wr = 0;
    endtask

    task automatic ticks(input int i, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tmr_tick[i] = 1;
            @(posedge clk); #1 tmr_tick[i] = 0;
        end
    endtask

    function automatic logic [7:0] cfg_byte();
        return {cfg_clk_speed, cfg_tmr_speed, cfg_tmr_run, cfg_ram_off, cfg_ram_wr_ok, cfg_tmr_halt};
    endfunction

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        @(negedge clk);
        check(boot_rom_en == 1, "R1 boot_rom_en", boot_rom_en, 1);
        check(tmr_en == 0 && cfg_byte() == 0, "R1 enables/config", {tmr_en, cfg_byte()}, 0);
        check(out_mbox == 0 && tmr_target == 0, "R1 mailbox/targets", out_mbox, 0);
        rd_chk(16'h00F2, 8'h00, "R1 dsp address");
        rd_chk(16'h00FD, 8'h00, "R1 counter 0");

        // R3 configuration byte
        p_flag = 1; wr(16'h00F0, 8'hFF); p_flag = 0;
        @(negedge clk); check(cfg_byte() == 8'h00, "R3 locked by p_flag", cfg_byte(), 0);
        wr(16'h00F0, 8'h9A);
        @(negedge clk);
        check(cfg_clk_speed == 2 && cfg_tmr_speed == 1 && cfg_tmr_run && !cfg_ram_off
              && cfg_ram_wr_ok && !cfg_tmr_halt, "R3 fields", cfg_byte(), 8'h9A);
        rd_chk(16'h00F0, 8'h00, "R8 cfg write-only");

        // R5 enable edges
        wr(16'h00F1, 8'h05);
        check(w_clr == 3'b101, "R5 clr pulses", w_clr, 3'b101);
        @(negedge clk); check(tmr_en == 3'b101 && !boot_rom_en, "R5/R4 enables+boot", {boot_rom_en, tmr_en}, 5);
        wr(16'h00F1, 8'h87);
        check(w_clr == 3'b010, "R5 only rising", w_clr, 3'b010);
        @(negedge clk); check(tmr_en == 3'b111 && boot_rom_en, "R4 boot bit", {boot_rom_en, tmr_en}, 8'hF);
        wr(16'h00F1, 8'h87);
        check(w_clr == 3'b000, "R5 no clr when held", w_clr, 0);
        rd_chk(16'h00F1, 8'h00, "R8 ctrl write-only");

        // R7 counters
        ticks(0, 5);
        rd_chk(16'h00FD, 8'h05, "R7 count 0");
        rd_chk(16'h00FD, 8'h00, "R7 cleared by read");
        ticks(1, 17);
        rd_chk(16'h00FE, 8'h01, "R7 wrap");
        ticks(0, 2);
        @(negedge clk); bus_addr = 16'h00FD; bus_rd = 1; tmr_tick[0] = 1;
        #2 check(bus_rdata == 8'h02, "R7 read with tick", bus_rdata, 2);
        @(posedge clk); #1 bus_rd = 0; tmr_tick[0] = 0;
        rd_chk(16'h00FD, 8'h00, "R7 clear beats tick");
        ticks(2, 3);
        wr(16'h00F1, 8'h83);
        wr(16'h00F1, 8'h87);
        rd_chk(16'h00FF, 8'h00, "R5 enable rise clears count");
        ticks(2, 4);
        wr(16'h00FF, 8'h0A);
        rd_chk(16'h00FF, 8'h04, "R8 counter write ignored");

        // R6 sound window
        wr(16'h00F2, 8'h85);
        wr(16'h00F3, 8'h33);
        check(w_dsp_we == 0, "R6 gated by bit7", w_dsp_we, 0);
        rd_chk(16'h00F2, 8'h85, "R6 address readback");
        @(negedge clk); check(dsp_addr == 7'h05, "R6 masked address", dsp_addr, 5);
        wr(16'h00F2, 8'h12);
        wr(16'h00F3, 8'h33);
        check(w_dsp_we && w_dsp_wdata == 8'h33, "R6 data write", {w_dsp_we, w_dsp_wdata}, 9'h133);
        dsp_rdata = 8'h5A;
        rd_chk(16'h00F3, 8'h5A, "R6 data read");

        // R2 decode
        ram_rdata = 8'hC3;
        rd_chk(16'h01F2, 8'hC3, "R2 outside page read");
        wr(16'h00E2, 8'h77);
        rd_chk(16'h00F2, 8'h12, "R2 outside write ignored");
        wr(16'hF0F2, 8'h66);
        rd_chk(16'h00F2, 8'h12, "R2 high byte decode");

        // R9/R10 random traffic
        for (int i = 0; i < 4; i++) begin m_inb[i] = 0; m_outb[i] = 0; end
        for (int i = 0; i < 2; i++) m_aux[i] = 0;
        for (int i = 0; i < 3; i++) m_tgt[i] = 0;
        for (int it = 0; it < 120; it++) begin
            int op = $urandom % 4;
            logic [7:0] d = 8'($urandom);
            if (op == 0) begin
                int k = $urandom % 4; hwr(2'(k), d); m_inb[k] = d;
            end else if (op == 1) begin
                int k = $urandom % 4; wr(16'h00F4 + 16'(k), d); m_outb[k] = d;
            end else if (op == 2) begin
                int k = $urandom % 2; wr(16'h00F8 + 16'(k), d); m_aux[k] = d;
            end else begin
                int k = $urandom % 3; wr(16'h00FA + 16'(k), d); m_tgt[k] = d;
            end
        end
        for (int k = 0; k < 4; k++) rd_chk(16'h00F4 + 16'(k), m_inb[k], "R9 inbound read");
        for (int k = 0; k < 2; k++) rd_chk(16'h00F8 + 16'(k), m_aux[k], "R10 spare readback");
        @(negedge clk);
        check(out_mbox == {m_outb[3], m_outb[2], m_outb[1], m_outb[0]}, "R9 outbound",
              out_mbox, {m_outb[3], m_outb[2], m_outb[1], m_outb[0]});
        check(tmr_target == {m_tgt[2], m_tgt[1], m_tgt[0]}, "R10 targets",
              tmr_target, {m_tgt[2], m_tgt[1], m_tgt[0]});
        for (int k = 0; k < 3; k++) rd_chk(16'h00FA + 16'(k), 8'h00, "R8 target write-only");

        // R4 mailbox clears
        for (int k = 0; k < 4; k++) hwr(2'(k), 8'h10 + 8'(k));
        wr(16'h00F1, 8'hA7);
        rd_chk(16'h00F6, 8'h00, "R4 clear byte 2");
        rd_chk(16'h00F7, 8'h00, "R4 clear byte 3");
        rd_chk(16'h00F4, 8'h10, "R4 byte 0 kept");
        @(negedge clk);
        bus_addr = 16'h00F1; bus_wdata = 8'h97; bus_wr = 1;
        host_wr = 1; host_idx = 0; host_wdata = 8'hEE;
        @(posedge clk); #1 bus_wr = 0; host_wr = 0;
        rd_chk(16'h00F4, 8'h00, "R4 clear beats host write");
        rd_chk(16'h00F5, 8'h00, "R4 clear byte 1");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule